// File: doc/BRIEF.md
# Serial Debug Memory Access Engine

This block carries out debug commands that a serial front end has already put into words. It accepts one command word at a time: an opcode, a selector, an address and an operand. It runs each command against a small bank of general registers, two address-space registers and a word-addressed memory master port. Every command except the null command produces exactly one result beat on the result stream. That beat holds either the data read or a zero completion word, and a flag that marks an illegal command.

Memory can be moved in blocks without sending an address for each access. A READ or WRITE sets the start address and the access size. Each later DUMP (after a READ) or FILL (after a WRITE) accesses the next location, stepping the address by the access size in bytes. The engine can also drive a peripheral reset line for a fixed number of cycles without resetting itself.

Top module: `dbgeng_top`

## Requirements
- R1: After reset, cmdReady is 1, while memReq, rspValid and rstOut are 0, and every general register and space register reads as 0.
- R2: Opcode 2 loads cmdData into the general register chosen by cmdSel (0..15) and returns a zero result. Opcode 1 returns that register's value. The result appears in the cycle after the command is accepted.
- R3: Opcode 4 loads cmdData[2:0] into the source space register (cmdSel=0) or the destination space register (cmdSel=1). Opcode 3 reads either one back, zero-extended. Memory reads place the source space on memSpace, and memory writes place the destination space there.
- R4: Opcode 5 (READ) starts a bus read in the cycle after acceptance. It drives memAddr=cmdAddr, memSize=cmdSel[1:0] (0 byte, 1 halfword, 2 word) and memWe=0. The result carries memRdata masked to the low 1, 2 or 4 bytes and appears in the cycle after memAck.
- R5: Opcode 6 (WRITE) starts a bus write with memWe=1 and cmdData masked to the access size on memWdata. Its result is a zero word with no illegal flag.
- R6: Opcode 7 (DUMP) after a READ, and opcode 8 (FILL) after a WRITE, each access the previous address plus 1, 2 or 4 bytes and reuse the previous access size. A FILL writes its own operand.
- R7: A DUMP whose last memory command was not a READ (or DUMP), or a FILL whose last was not a WRITE (or FILL), returns the illegal flag and makes no bus request.
- R8: Opcode 9 raises rstOut for exactly 512 cycles, starting the cycle after acceptance, and returns a zero result. It leaves registers unchanged, and commands are still accepted during the pulse.
- R9: Opcode 0 (NOP) produces no result and no bus request.
- R10: While a bus request waits for memAck, cmdReady is 0, and memReq and memAddr hold steady.
- R11: Opcodes 10..15, and a READ or WRITE with size code 3, return the illegal flag with zero data and make no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmdValid | input | 1 | Command word present |
| cmdReady | output | 1 | Engine can take a command |
| cmdOp | input | 4 | Command opcode |
| cmdSel | input | 4 | Register index, space selector or size code |
| cmdAddr | input | 32 | Byte address for READ/WRITE |
| cmdData | input | 32 | Operand |
| rspValid | output | 1 | One-cycle result strobe |
| rspIll | output | 1 | Result flags an illegal command |
| rspData | output | 32 | Result data |
| memReq | output | 1 | Bus request, held until acknowledged |
| memWe | output | 1 | 1 for write, 0 for read |
| memAddr | output | 32 | Byte address of the access |
| memSize | output | 2 | Access size code |
| memSpace | output | 3 | Address-space tag |
| memWdata | output | 32 | Write data, masked to size |
| memRdata | input | 32 | Read data, right-justified |
| memAck | input | 1 | Bus access complete |
| rstOut | output | 1 | Peripheral reset pulse |

## Verification
The assertions watch properties that hold on every cycle. A waiting bus request keeps its address and blocks new commands. A reset pulse never runs past its length and ends at exactly 512 high cycles. A DUMP or FILL outside its chain never reaches the bus, and a NOP leaves both the result stream and the bus quiet. Only the bench scenarios can show the data behaviour: the address stepping by each access size, the byte masking against a little-endian memory model, the choice between source and destination space, and registers surviving a reset pulse.

// File: rtl/dbgeng_pkg.sv
package dbgeng_pkg;

  localparam logic [3:0] OP_NOP   = 4'd0;
  localparam logic [3:0] OP_RREG  = 4'd1;
  localparam logic [3:0] OP_WREG  = 4'd2;
  localparam logic [3:0] OP_RSYS  = 4'd3;
  localparam logic [3:0] OP_WSYS  = 4'd4;
  localparam logic [3:0] OP_READ  = 4'd5;
  localparam logic [3:0] OP_WRITE = 4'd6;
  localparam logic [3:0] OP_DUMP  = 4'd7;
  localparam logic [3:0] OP_FILL  = 4'd8;
  localparam logic [3:0] OP_PRST  = 4'd9;

  typedef enum logic [1:0] {SRC_NONE, SRC_REG, SRC_SYS, SRC_MEM} rsp_src_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     regWr;
    logic     sysWr;
    logic     startRd;
    logic     startWr;
    logic     nextRd;
    logic     nextWr;
    logic     rspLoad;
    logic     rspIll;
    rsp_src_e rspSrc;
  } strb_t;

  function automatic logic [2:0] sizeBytes(input logic [1:0] s);
    case (s)
      2'd0:    sizeBytes = 3'd1;
      2'd1:    sizeBytes = 3'd2;
      default: sizeBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dbgeng_dp.sv
module dbgeng_dp
  import dbgeng_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int NREG = 16,
  parameter int SPW  = 3,
  localparam int RIW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  strb_t           strb,
  input  logic [RIW-1:0]  cmdSel,
  input  logic [AW-1:0]   cmdAddr,
  input  logic [DW-1:0]   cmdData,
  input  logic [DW-1:0]   memRdata,
  output logic [AW-1:0]   memAddr,
  output logic [1:0]      memSize,
  output logic [SPW-1:0]  memSpace,
  output logic [DW-1:0]   memWdata,
  output logic            rspValid,
  output logic            rspIll,
  output logic [DW-1:0]   rspData
);

  function automatic logic [DW-1:0] sizeMask(input logic [DW-1:0] v, input logic [1:0] s);
    case (s)
      2'd0:    sizeMask = {{(DW-8){1'b0}}, v[7:0]};
      2'd1:    sizeMask = {{(DW-16){1'b0}}, v[15:0]};
      default: sizeMask = v;
    endcase
  endfunction

  logic [DW-1:0]  regView [NREG];
  logic [SPW-1:0] srcSp, dstSp;
  logic [AW-1:0]  accAddr, nextAddr;
  logic [1:0]     accSize;
  logic [SPW-1:0] accSpace;
  logic [DW-1:0]  accWdata;
  logic [DW-1:0]  sysRd, rspNext;

  for (genvar i = 0; i < NREG; i++) begin : gen_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (strb.regWr && cmdSel == RIW'(i)) q <= cmdData;
    end
    assign regView[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcSp <= '0;
      dstSp <= '0;
    end else if (strb.sysWr) begin
      if (cmdSel == RIW'(0)) srcSp <= cmdData[SPW-1:0];
      if (cmdSel == RIW'(1)) dstSp <= cmdData[SPW-1:0];
    end
  end

  assign nextAddr = accAddr + AW'(sizeBytes(accSize));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accAddr  <= '0;
      accSize  <= '0;
      accSpace <= '0;
      accWdata <= '0;
    end else if (strb.startRd || strb.startWr) begin
      accAddr  <= cmdAddr;
      accSize  <= cmdSel[1:0];
      accSpace <= strb.startWr ? dstSp : srcSp;
      accWdata <= sizeMask(cmdData, cmdSel[1:0]);
    end else if (strb.nextRd || strb.nextWr) begin
      accAddr  <= nextAddr;
      accSpace <= strb.nextWr ? dstSp : srcSp;
      accWdata <= sizeMask(cmdData, accSize);
    end
  end

  always_comb begin
    sysRd = '0;
    if (cmdSel == RIW'(0)) sysRd = {{(DW-SPW){1'b0}}, srcSp};
    if (cmdSel == RIW'(1)) sysRd = {{(DW-SPW){1'b0}}, dstSp};
    case (strb.rspSrc)
      SRC_REG: rspNext = regView[cmdSel];
      SRC_SYS: rspNext = sysRd;
      SRC_MEM: rspNext = sizeMask(memRdata, accSize);
      default: rspNext = '0;
    endcase
    if (strb.rspIll) rspNext = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspIll   <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.rspLoad;
      if (strb.rspLoad) begin
        rspIll  <= strb.rspIll;
        rspData <= rspNext;
      end
    end
  end

  assign memAddr  = accAddr;
  assign memSize  = accSize;
  assign memSpace = accSpace;
  assign memWdata = accWdata;

endmodule

// File: rtl/dbgeng_ctrl.sv
module dbgeng_ctrl
  import dbgeng_pkg::*;
#(
  parameter int RST_CYCLES = 512,
  localparam int CW = $clog2(RST_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdValid,
  input  logic [3:0] cmdOp,
  input  logic [1:0] cmdSize,
  input  logic       memAck,
  output logic       cmdReady,
  output logic       memReq,
  output logic       memWe,
  output logic       rstOut,
  output strb_t      strb
);

  typedef enum logic {S_IDLE, S_BUS} state_e;
  typedef enum logic [1:0] {CH_NONE, CH_RD, CH_WR} chain_e;

  state_e        state;
  chain_e        chain, nxtChain;
  logic          goBus, goWe, loadRst, accept;
  logic [CW-1:0] rstCnt;

  assign accept   = cmdValid && (state == S_IDLE);
  assign cmdReady = (state == S_IDLE);
  assign memReq   = (state == S_BUS);
  assign rstOut   = (rstCnt != '0);

  always_comb begin
    strb     = '0;
    goBus    = 1'b0;
    goWe     = 1'b0;
    loadRst  = 1'b0;
    nxtChain = chain;
    if (accept) begin
      case (cmdOp)
        OP_NOP: ;
        OP_RREG: begin strb.rspLoad = 1'b1; strb.rspSrc = SRC_REG; end
        OP_WREG: begin strb.regWr = 1'b1; strb.rspLoad = 1'b1; end
        OP_RSYS: begin strb.rspLoad = 1'b1; strb.rspSrc = SRC_SYS; end
        OP_WSYS: begin strb.sysWr = 1'b1; strb.rspLoad = 1'b1; end
        OP_READ, OP_WRITE: begin
          if (cmdSize == 2'd3) begin
            strb.rspLoad = 1'b1;
            strb.rspIll  = 1'b1;
          end else begin
            goBus        = 1'b1;
            goWe         = (cmdOp == OP_WRITE);
            strb.startRd = !goWe;
            strb.startWr = goWe;
            nxtChain     = goWe ? CH_WR : CH_RD;
          end
        end
        OP_DUMP: begin
          if (chain == CH_RD) begin
            goBus       = 1'b1;
            strb.nextRd = 1'b1;
          end else begin
            strb.rspLoad = 1'b1;
            strb.rspIll  = 1'b1;
          end
        end
        OP_FILL: begin
          if (chain == CH_WR) begin
            goBus       = 1'b1;
            goWe        = 1'b1;
            strb.nextWr = 1'b1;
          end else begin
            strb.rspLoad = 1'b1;
            strb.rspIll  = 1'b1;
          end
        end
        OP_PRST: begin loadRst = 1'b1; strb.rspLoad = 1'b1; end
        default: begin strb.rspLoad = 1'b1; strb.rspIll = 1'b1; end
      endcase
    end else if (state == S_BUS && memAck) begin
      strb.rspLoad = 1'b1;
      strb.rspSrc  = memWe ? SRC_NONE : SRC_MEM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      chain  <= CH_NONE;
      memWe  <= 1'b0;
      rstCnt <= '0;
    end else begin
      chain <= nxtChain;
      if (loadRst)          rstCnt <= CW'(RST_CYCLES);
      else if (rstCnt != 0) rstCnt <= rstCnt - 1'b1;
      if (goBus) begin
        state <= S_BUS;
        memWe <= goWe;
      end else if (state == S_BUS && memAck) begin
        state <= S_IDLE;
      end
    end
  end

  // independent length counter for the reset pulse
  logic [CW:0] rstLen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rstLen <= '0;
    else if (loadRst) rstLen <= '0;
    else if (rstOut)  rstLen <= rstLen + 1'b1;
  end

  a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rstOut) |-> rstLen == (CW+1)'(RST_CYCLES));

  a_r8_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rstOut |-> rstLen < (CW+1)'(RST_CYCLES));

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> memReq);

  a_r7_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ((cmdOp == OP_DUMP && chain != CH_RD) ||
               (cmdOp == OP_FILL && chain != CH_WR)) |=> !memReq);

endmodule

// File: rtl/dbgeng_top.sv
module dbgeng_top
  import dbgeng_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int SPW        = 3,
  parameter int RST_CYCLES = 512,
  localparam int RIW       = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmdValid,
  output logic           cmdReady,
  input  logic [3:0]     cmdOp,
  input  logic [RIW-1:0] cmdSel,
  input  logic [AW-1:0]  cmdAddr,
  input  logic [DW-1:0]  cmdData,
  output logic           rspValid,
  output logic           rspIll,
  output logic [DW-1:0]  rspData,
  output logic           memReq,
  output logic           memWe,
  output logic [AW-1:0]  memAddr,
  output logic [1:0]     memSize,
  output logic [SPW-1:0] memSpace,
  output logic [DW-1:0]  memWdata,
  input  logic [DW-1:0]  memRdata,
  input  logic           memAck,
  output logic           rstOut
);

  strb_t strb;

  dbgeng_ctrl #(.RST_CYCLES(RST_CYCLES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdSize(cmdSel[1:0]), .memAck(memAck), .cmdReady(cmdReady),
    .memReq(memReq), .memWe(memWe), .rstOut(rstOut), .strb(strb)
  );

  dbgeng_dp #(.DW(DW), .AW(AW), .NREG(NREG), .SPW(SPW)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cmdSel(cmdSel),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .memRdata(memRdata),
    .memAddr(memAddr), .memSize(memSize), .memSpace(memSpace),
    .memWdata(memWdata), .rspValid(rspValid), .rspIll(rspIll),
    .rspData(rspData)
  );

  a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> $stable(memAddr));

  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> !cmdReady);

  a_r9_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && cmdReady && cmdOp == OP_NOP |=> !rspValid && !memReq);

endmodule

// File: tb/dbgeng_tb.sv
`timescale 1ns/1ps
module dbgeng_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [3:0]  cmdOp = '0;
  logic [3:0]  cmdSel = '0;
  logic [31:0] cmdAddr = '0;
  logic [31:0] cmdData = '0;
  logic        rspValid, rspIll;
  logic [31:0] rspData;
  logic        memReq, memWe;
  logic [31:0] memAddr;
  logic [1:0]  memSize;
  logic [2:0]  memSpace;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic        rstOut;

  always #4 clk = ~clk;

  dbgeng_top dut_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdSel(cmdSel), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .rspValid(rspValid), .rspIll(rspIll), .rspData(rspData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memSize(memSize),
    .memSpace(memSpace), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck), .rstOut(rstOut)
  );

  int total = 0;
  int bad = 0;

  // little-endian byte memory, acknowledges on the second cycle of a request
  logic [7:0] mem [256];
  int reqAge = 0;
  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  always @(negedge clk) begin
    if (memReq && !memAck) begin
      reqAge = reqAge + 1;
      if (reqAge == 2) begin
        memAck = 1'b1;
        memRdata = {mem[8'(memAddr+3)], mem[8'(memAddr+2)],
                    mem[8'(memAddr+1)], mem[8'(memAddr)]};
        if (memWe) begin
          mem[8'(memAddr)] = memWdata[7:0];
          if (memSize != 2'd0) mem[8'(memAddr+1)] = memWdata[15:8];
          if (memSize == 2'd2) begin
            mem[8'(memAddr+2)] = memWdata[23:16];
            mem[8'(memAddr+3)] = memWdata[31:24];
          end
        end
      end
    end else begin
      memAck = 1'b0;
      reqAge = 0;
    end
  end

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one command; returns at the negedge after its acceptance edge
  task automatic issue(input logic [3:0] op, input logic [3:0] sel,
                       input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdSel = sel; cmdAddr = addr; cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitRsp(output bit got, output bit ill, output logic [31:0] data);
    got = 0; ill = 0; data = '0;
    for (int k = 0; k < 10; k++) begin
      if (rspValid) begin
        got = 1; ill = rspIll; data = rspData;
        break;
      end
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  sel;
    logic [31:0] addr;
    logic [31:0] data;
    logic        expRsp;
    logic        expIll;
    logic [31:0] expData;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 4'd5,  32'h0,  32'h0,        1'b1, 1'b0, 32'h0,        4'd1},  // R1 register clear
    '{4'd2, 4'd3,  32'h0,  32'hDEADBEEF, 1'b1, 1'b0, 32'h0,        4'd2},  // R2
    '{4'd2, 4'd12, 32'h0,  32'h00001000, 1'b1, 1'b0, 32'h0,        4'd2},
    '{4'd1, 4'd3,  32'h0,  32'h0,        1'b1, 1'b0, 32'hDEADBEEF, 4'd2},
    '{4'd1, 4'd12, 32'h0,  32'h0,        1'b1, 1'b0, 32'h00001000, 4'd2},
    '{4'd0, 4'd0,  32'h0,  32'h0,        1'b0, 1'b0, 32'h0,        4'd9},  // R9
    '{4'd7, 4'd0,  32'h0,  32'h0,        1'b1, 1'b1, 32'h0,        4'd7},  // R7
    '{4'd8, 4'd0,  32'h0,  32'h0,        1'b1, 1'b1, 32'h0,        4'd7},
    '{4'd4, 4'd0,  32'h0,  32'h5,        1'b1, 1'b0, 32'h0,        4'd3},  // R3
    '{4'd4, 4'd1,  32'h0,  32'hB,        1'b1, 1'b0, 32'h0,        4'd3},
    '{4'd3, 4'd0,  32'h0,  32'h0,        1'b1, 1'b0, 32'h5,        4'd3},
    '{4'd3, 4'd1,  32'h0,  32'h0,        1'b1, 1'b0, 32'h3,        4'd3},
    '{4'd6, 4'd2,  32'h10, 32'h11223344, 1'b1, 1'b0, 32'h0,        4'd5},  // R5
    '{4'd8, 4'd0,  32'h0,  32'hAABBCCDD, 1'b1, 1'b0, 32'h0,        4'd6},  // R6 to 0x14
    '{4'd7, 4'd0,  32'h0,  32'h0,        1'b1, 1'b1, 32'h0,        4'd7},
    '{4'd5, 4'd2,  32'h10, 32'h0,        1'b1, 1'b0, 32'h11223344, 4'd4},  // R4
    '{4'd7, 4'd0,  32'h0,  32'h0,        1'b1, 1'b0, 32'hAABBCCDD, 4'd6},
    '{4'd8, 4'd0,  32'h0,  32'h0,        1'b1, 1'b1, 32'h0,        4'd7},
    '{4'd5, 4'd0,  32'h11, 32'h0,        1'b1, 1'b0, 32'h33,       4'd4},
    '{4'd7, 4'd0,  32'h0,  32'h0,        1'b1, 1'b0, 32'h22,       4'd6},
    '{4'd5, 4'd1,  32'h14, 32'h0,        1'b1, 1'b0, 32'hCCDD,     4'd4},
    '{4'd7, 4'd0,  32'h0,  32'h0,        1'b1, 1'b0, 32'hAABB,     4'd6},
    '{4'd5, 4'd3,  32'h0,  32'h0,        1'b1, 1'b1, 32'h0,        4'd11}, // R11
    '{4'd15,4'd0,  32'h0,  32'h0,        1'b1, 1'b1, 32'h0,        4'd11},
    '{4'd6, 4'd0,  32'h20, 32'h123456FF, 1'b1, 1'b0, 32'h0,        4'd5},
    '{4'd8, 4'd0,  32'h0,  32'h00000077, 1'b1, 1'b0, 32'h0,        4'd6},
    '{4'd5, 4'd1,  32'h20, 32'h0,        1'b1, 1'b0, 32'h77FF,     4'd6}
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired: actual=%h expected=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit got, ill;
    logic [31:0] data;
    int hi;

    // the source space is reprogrammed to 5 below; vector 11 expects 3 for dst
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cmdReady == 1'b1, 1, "cmdReady after reset", 32'(cmdReady), 32'd1);
    check(!memReq && !rspValid && !rstOut, 1, "outputs idle after reset",
          {29'd0, memReq, rspValid, rstOut}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      vec_t e;
      e = VECS[v];
      // dst space written as 0xB: only 3 bits kept (R3)
      issue(e.op, e.sel, e.addr, e.data);
      waitRsp(got, ill, data);
      check(got == e.expRsp, int'(e.req), $sformatf("vec %0d response present", v),
            32'(got), 32'(e.expRsp));
      if (e.expRsp) begin
        check(ill == e.expIll, int'(e.req), $sformatf("vec %0d illegal flag", v),
              32'(ill), 32'(e.expIll));
        check(data == e.expData, int'(e.req), $sformatf("vec %0d data", v),
              data, e.expData);
      end
      if (!e.expRsp || e.expIll)
        check(!memReq, int'(e.req), $sformatf("vec %0d no bus request", v),
              32'(memReq), 32'd0);
    end

    // R4 / R3 / R10: bus read timing and held request
    issue(4'd5, 4'd2, 32'h10, 32'h0);
    check(memReq == 1'b1, 4, "read request cycle after accept", 32'(memReq), 32'd1);
    check(memAddr == 32'h10 && memSize == 2'd2 && memWe == 1'b0, 4, "read address/size/we",
          memAddr, 32'h10);
    check(memSpace == 3'd5, 3, "read uses source space", 32'(memSpace), 32'd5);
    check(cmdReady == 1'b0, 10, "not ready while waiting", 32'(cmdReady), 32'd0);
    @(negedge clk);
    check(memReq && !cmdReady && memAddr == 32'h10, 10, "request held until ack",
          memAddr, 32'h10);
    waitRsp(got, ill, data);
    check(got && !ill && data == 32'h11223344, 4, "read result after ack", data, 32'h11223344);

    // R5 / R3: write with destination space and masking
    issue(4'd6, 4'd0, 32'h30, 32'hCAFE12AB);
    check(memWe && memSize == 2'd0 && memWdata == 32'hAB, 5, "byte write data masked",
          memWdata, 32'hAB);
    check(memSpace == 3'd3, 3, "write uses destination space", 32'(memSpace), 32'd3);
    waitRsp(got, ill, data);
    check(got && !ill && data == 32'h0, 5, "write completion", data, 32'h0);

    // R6: fill steps by one byte
    issue(4'd8, 4'd0, 32'h0, 32'h1299);
    check(memAddr == 32'h31 && memWdata == 32'h99, 6, "fill next address", memAddr, 32'h31);
    waitRsp(got, ill, data);
    check(got && !ill, 6, "fill completion", 32'(ill), 32'd0);

    // R8: peripheral reset pulse
    issue(4'd9, 4'd0, 32'h0, 32'h0);
    waitRsp(got, ill, data);
    check(got && !ill && data == 32'h0, 8, "reset command result", data, 32'h0);
    check(cmdReady == 1'b1, 8, "ready during pulse", 32'(cmdReady), 32'd1);
    hi = 0;
    for (int k = 0; k < 600 && rstOut; k++) begin
      hi++;
      @(negedge clk);
    end
    check(hi == 512, 8, "pulse length", 32'(hi), 32'd512);
    issue(4'd1, 4'd3, 32'h0, 32'h0);
    waitRsp(got, ill, data);
    check(got && data == 32'hDEADBEEF, 8, "register kept across pulse", data, 32'hDEADBEEF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule